// File: doc/BRIEF.md
# Interrupt Status Collector with Read-Clear

This block gathers the event and fault sources of an isolated multi-channel converter front end into one 16-bit sticky status word. It also drives a single active-low interrupt line. Five sources have fixed bit positions. Each one sets its bit on the clock edge where it is seen:

- the end of a four-channel conversion sweep;
- a converter self-test failure;
- loss of the periodic data stream from the field side;
- a CRC fault on the internal link;
- an SPI framing error.

Below these, rising and falling edges of each channel comparator set one bit per channel and per direction. A per-bit enable word selects which set bits pull the interrupt low. A source whose enable is off still records its bit.

The host reads the status word through an SPI transaction that lives outside this block. It marks the start of that read with `rd_start` and the end with `rd_end`. When the read ends, every bit that was set when the read began is cleared, even if its event fired again during the read. A bit that first appeared during the read survives. A fault that is still present after the clear shows up again at once.

The block also owns three counters:
- a timer that stretches end of conversion into a fixed-width interrupt pulse, independent of reads;
- a watchdog for the periodic data beat, held off for a startup period after reset;
- a counter of consecutive failed link checks.

All periods are parameters given in system-clock ticks per microsecond. The block has no streaming data path: every pin is a plain control or status signal sampled each cycle.

Top module: `irq_status_hub`

## Requirements
- R1: After reset `status_q` reads 0x0000 and `irq_n` is 1.
- R2: An event seen at a rising clock edge sets its bit in `status_q` from that edge on. Bit positions:
  - end of conversion: bit 12;
  - converter fault: bit 11;
  - data-stream loss: bit 10;
  - SPI framing error: bit 9;
  - CRC fault: bit 8;
  - comparator rise on channel i: bit i;
  - comparator fall on channel i: bit 4+i.
  
  Bits 15:13 always read 0.
- R3: A set bit stays set until a read transaction ends.
- R4: `irq_n` is 0 whenever any bit other than bit 12 is set in both `status_q` and `irq_en`. A source whose enable bit is 0 still sets its status bit.
- R5: At the edge that samples `rd_end` of an open read, every bit that was 1 at the edge sampling `rd_start` is cleared.
- R6: A bit that was 0 when the read opened and is set before or at `rd_end` is 1 after the read.
- R7: A bit that was 1 when the read opened is 0 after the read even if its event fired again during the read, unless the event is present in the `rd_end` cycle itself.
- R8: The converter fault, data-stream loss and CRC fault are conditions. If the condition still holds at `rd_end`, its bit is 1 in the cycle after the read.
- R9: An end-of-conversion event pulls `irq_n` low for exactly EOC_US×TICKS_PER_US cycles when `irq_en[12]` is 1. After that the line releases even if bit 12 remains set and unread; bit 12 by itself never holds `irq_n` low.
- R10: Data-stream loss holds when GAP_US×TICKS_PER_US cycles pass with no `link_data_ok` pulse. It is masked until STARTUP_US×TICKS_PER_US cycles after reset.
- R11: The CRC fault holds after CRC_LIMIT consecutive `link_crc_bad` pulses (default 6). A `link_crc_good` pulse resets the run and ends the fault; good wins if both arrive in the same cycle.
- R12: A `rd_start` during an open read is ignored; it does not retake the snapshot. A `rd_end` with no open read has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc_evt | input | 1 | One-cycle pulse at the end of the channel sweep |
| adc_fault | input | 1 | Converter self-test failure condition (level) |
| link_data_ok | input | 1 | One-cycle pulse per periodic data beat received |
| link_crc_good | input | 1 | One-cycle pulse for a passing link CRC check |
| link_crc_bad | input | 1 | One-cycle pulse for a failing link CRC check |
| spi_frame_err | input | 1 | One-cycle pulse for a bad SPI frame length |
| cmp_rise | input | NCH | Per-channel comparator rising-edge pulses |
| cmp_fall | input | NCH | Per-channel comparator falling-edge pulses |
| irq_en | input | 16 | Per-bit interrupt enables |
| rd_start | input | 1 | Pulse: a read of the status word begins |
| rd_end | input | 1 | Pulse: that read transaction ends |
| status_q | output | 16 | Sticky status word |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Every source lands in `status_q` at the rising edge that samples it. The interrupt line follows combinationally from the status bits and enables, so both show a stimulus at the falling edge one half-cycle after it is sampled.

The bench drives all inputs at falling edges and samples at the next falling edge. A behavioural model advances at each rising edge on the same inputs, and its status word and interrupt level are compared with the outputs every falling edge.

The directed checks count out the longer results in cycles:
- the end-of-conversion pulse is low for ten falling edges and high on the eleventh;
- the CRC fault appears after the sixth bad check;
- the loss bit is still 0 shortly before the startup mask lifts and 1 just after it.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int REG_W     = 16;
  localparam int BIT_EOC   = 12;
  localparam int BIT_CNV   = 11;
  localparam int BIT_LOSS  = 10;
  localparam int BIT_FRM   = 9;
  localparam int BIT_CRC   = 8;
  localparam int CMP_FIELD = 8;
  localparam int CMP_HALF  = CMP_FIELD / 2;
  typedef logic [REG_W-1:0] irq_vec_t;
endpackage

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (trig)         cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/irq_stream_watchdog.sv
module irq_stream_watchdog #(
  parameter int STARTUP_TICKS = 10000000,
  parameter int GAP_TICKS     = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  output logic armed,
  output logic lost
);
  localparam int SW = $clog2(STARTUP_TICKS + 1);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam logic [SW-1:0] SU_END  = SW'(STARTUP_TICKS);
  localparam logic [GW-1:0] GAP_END = GW'(GAP_TICKS);

  logic [SW-1:0] su_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            su_q <= '0;
    else if (su_q != SU_END) su_q <= su_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap_q <= '0;
    else if (beat)            gap_q <= '0;
    else if (gap_q != GAP_END) gap_q <= gap_q + 1'b1;
  end

  assign armed = (su_q == SU_END);
  assign lost  = armed && (gap_q == GAP_END);
endmodule

// File: rtl/irq_crc_streak.sv
module irq_crc_streak #(
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good,
  input  logic bad,
  output logic fault
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_q <= '0;
    else if (good)               run_q <= '0;
    else if (bad && run_q != TOP) run_q <= run_q + 1'b1;
  end

  assign fault = (run_q == TOP);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_hub_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t set_vec,
  input  logic     rd_start,
  input  logic     rd_end,
  output irq_vec_t status,
  output logic     rd_act,
  output irq_vec_t snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      rd_act <= 1'b0;
      snap   <= '0;
    end else if (rd_end && rd_act) begin
      // bits present at read open are dropped; anything new survives
      status <= (status & ~snap) | set_vec;
      rd_act <= 1'b0;
    end else begin
      status <= status | set_vec;
      if (rd_start && !rd_act) begin
        rd_act <= 1'b1;
        snap   <= status;
      end
    end
  end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
  import irq_hub_pkg::*;
#(
  parameter int NCH          = 4,
  parameter int TICKS_PER_US = 100,
  parameter int EOC_US       = 10,
  parameter int GAP_US       = 50,
  parameter int STARTUP_US   = 100000,
  parameter int CRC_LIMIT    = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           eoc_evt,
  input  logic           adc_fault,
  input  logic           link_data_ok,
  input  logic           link_crc_good,
  input  logic           link_crc_bad,
  input  logic           spi_frame_err,
  input  logic [NCH-1:0] cmp_rise,
  input  logic [NCH-1:0] cmp_fall,
  input  logic [15:0]    irq_en,
  input  logic           rd_start,
  input  logic           rd_end,
  output logic [15:0]    status_q,
  output logic           irq_n
);
  localparam int EOC_TICKS     = TICKS_PER_US * EOC_US;
  localparam int GAP_TICKS     = TICKS_PER_US * GAP_US;
  localparam int STARTUP_TICKS = TICKS_PER_US * STARTUP_US;
  localparam irq_vec_t LVL_MASK = ~(irq_vec_t'(1) << BIT_EOC);

  irq_vec_t set_vec, rd_snap;
  logic     rd_act, eoc_on, wd_armed, wd_lost, crc_flt;

  irq_pulse_timer #(.TICKS(EOC_TICKS)) u_eoc (
    .clk(clk), .rst_n(rst_n), .trig(eoc_evt), .active(eoc_on)
  );

  irq_stream_watchdog #(.STARTUP_TICKS(STARTUP_TICKS), .GAP_TICKS(GAP_TICKS)) u_wd (
    .clk(clk), .rst_n(rst_n), .beat(link_data_ok), .armed(wd_armed), .lost(wd_lost)
  );

  irq_crc_streak #(.LIMIT(CRC_LIMIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .good(link_crc_good), .bad(link_crc_bad), .fault(crc_flt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_EOC]  = eoc_evt;
    set_vec[BIT_CNV]  = adc_fault;
    set_vec[BIT_LOSS] = wd_lost;
    set_vec[BIT_FRM]  = spi_frame_err;
    set_vec[BIT_CRC]  = crc_flt;
    for (int i = 0; i < NCH; i++) begin
      set_vec[i]            = cmp_rise[i];
      set_vec[CMP_HALF + i] = cmp_fall[i];
    end
  end

  irq_status_reg u_reg (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_start(rd_start),
    .rd_end(rd_end), .status(status_q), .rd_act(rd_act), .snap(rd_snap)
  );

  always_comb begin
    irq_n = ~((|(status_q & irq_en & LVL_MASK)) | (irq_en[BIT_EOC] & eoc_on));
  end
endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker
  import irq_hub_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     eoc_evt,
  input logic     link_crc_good,
  input logic     rd_end,
  input irq_vec_t irq_en,
  input irq_vec_t status_q,
  input logic     irq_n,
  input irq_vec_t set_vec,
  input logic     rd_act,
  input irq_vec_t snap,
  input logic     armed,
  input logic     lost,
  input logic     crc_flt
);
  localparam irq_vec_t NOT_EOC = ~(irq_vec_t'(1) << BIT_EOC);

  assert_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[15:13] == 3'b000);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_end && rd_act) |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & irq_en & NOT_EOC) != '0) |-> !irq_n);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && rd_act) |=> ((status_q & $past(snap)) == ($past(set_vec) & $past(snap))));

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && rd_act) |=>
      ((status_q & ~$past(snap)) == (($past(status_q) | $past(set_vec)) & ~$past(snap))));

  assert_eoc_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_evt |=> (!irq_en[BIT_EOC] || !irq_n));

  assert_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !lost);

  assert_good_R11: assert property (@(posedge clk) disable iff (!rst_n)
    link_crc_good |=> !crc_flt);
endmodule

bind irq_status_hub irq_hub_checker u_chk (
  .clk(clk), .rst_n(rst_n), .eoc_evt(eoc_evt), .link_crc_good(link_crc_good),
  .rd_end(rd_end), .irq_en(irq_en), .status_q(status_q), .irq_n(irq_n),
  .set_vec(set_vec), .rd_act(rd_act), .snap(rd_snap), .armed(wd_armed),
  .lost(wd_lost), .crc_flt(crc_flt)
);

// File: tb/irq_status_hub_test.sv
module irq_status_hub_test;
  localparam int NCH = 4, TPU = 1, EOC_US = 10, GAP_US = 50, SU_US = 2000, CRCL = 6;
  localparam int T_EOC = TPU * EOC_US, T_GAP = TPU * GAP_US, T_SU = TPU * SU_US;

  logic clk = 1'b0, rst_n = 1'b0;
  logic eoc_evt = 0, adc_fault = 0, link_data_ok = 0, link_crc_good = 0, link_crc_bad = 0;
  logic spi_frame_err = 0, rd_start = 0, rd_end = 0;
  logic [NCH-1:0] cmp_rise = '0, cmp_fall = '0;
  logic [15:0] irq_en = '0;
  logic [15:0] status_q;
  logic irq_n;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0, feed_on = 0;

  always #5 clk = ~clk;

  irq_status_hub #(.NCH(NCH), .TICKS_PER_US(TPU), .EOC_US(EOC_US), .GAP_US(GAP_US),
                   .STARTUP_US(SU_US), .CRC_LIMIT(CRCL)) uut (
    .clk(clk), .rst_n(rst_n), .eoc_evt(eoc_evt), .adc_fault(adc_fault),
    .link_data_ok(link_data_ok), .link_crc_good(link_crc_good), .link_crc_bad(link_crc_bad),
    .spi_frame_err(spi_frame_err), .cmp_rise(cmp_rise), .cmp_fall(cmp_fall),
    .irq_en(irq_en), .rd_start(rd_start), .rd_end(rd_end), .status_q(status_q), .irq_n(irq_n)
  );

  // behavioural reference model
  logic [15:0] m_st = '0, m_snap = '0;
  bit m_act = 0;
  int m_pulse = 0, m_su = 0, m_gap = 0, m_crc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = '0; m_snap = '0; m_act = 0; m_pulse = 0; m_su = 0; m_gap = 0; m_crc = 0; cyc = 0;
    end else begin
      logic [15:0] s, old;
      bit old_act;
      cyc++;
      s = '0;
      s[12] = eoc_evt; s[11] = adc_fault; s[10] = (m_su == T_SU) && (m_gap == T_GAP);
      s[9] = spi_frame_err; s[8] = (m_crc == CRCL);
      for (int i = 0; i < NCH; i++) begin s[i] = cmp_rise[i]; s[4+i] = cmp_fall[i]; end
      old = m_st; old_act = m_act;
      if (rd_end && old_act) begin m_st = (old & ~m_snap) | s; m_act = 0; end
      else begin
        m_st = old | s;
        if (rd_start && !old_act) begin m_snap = old; m_act = 1; end
      end
      m_pulse = eoc_evt ? T_EOC : (m_pulse > 0 ? m_pulse - 1 : 0);
      if (m_su < T_SU) m_su++;
      m_gap = link_data_ok ? 0 : (m_gap < T_GAP ? m_gap + 1 : m_gap);
      m_crc = link_crc_good ? 0 : ((link_crc_bad && m_crc < CRCL) ? m_crc + 1 : m_crc);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_irq;
      exp_irq = !(((m_st & irq_en & 16'hEFFF) != 0) || (irq_en[12] && m_pulse > 0));
      total++;
      if (status_q !== m_st) begin
        bad++; $display("FAIL R3 model status: actual=%h expected=%h cyc=%0d", status_q, m_st, cyc);
      end
      total++;
      if (irq_n !== exp_irq) begin
        bad++; $display("FAIL R4 model irq_n: actual=%b expected=%b cyc=%0d", irq_n, exp_irq, cyc);
      end
    end
  end

  // periodic data beat source
  initial begin
    int fc = 0;
    forever begin
      @(negedge clk);
      fc++;
      link_data_ok = feed_on && (fc % 10 == 0);
    end
  end

  task automatic chk(string tag, logic [15:0] mask, logic [15:0] exp);
    total++;
    if ((status_q & mask) !== exp) begin
      bad++; $display("FAIL %s: actual=%h expected=%h", tag, status_q & mask, exp);
    end
  endtask

  task automatic chk_irq(string tag, logic exp);
    total++;
    if (irq_n !== exp) begin
      bad++; $display("FAIL %s: actual=%b expected=%b", tag, irq_n, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd_start = 1; @(negedge clk) rd_start = 0;
    @(negedge clk) rd_end = 1;   @(negedge clk) rd_end = 0;
  endtask

  initial begin
    tick(4);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", 16'hFFFF, 16'h0000);
    chk_irq("R1 reset irq_n", 1'b1);

    @(negedge clk) cmp_rise[2] = 1; @(negedge clk) cmp_rise[2] = 0;
    chk("R2 cmp rise ch2 bit2", 16'h00FF, 16'h0004);
    @(negedge clk) cmp_fall[1] = 1; @(negedge clk) cmp_fall[1] = 0;
    chk("R2 cmp fall ch1 bit5", 16'h00FF, 16'h0024);

    @(negedge clk) spi_frame_err = 1; @(negedge clk) spi_frame_err = 0;
    chk("R4 disabled source latches bit9", 16'h0200, 16'h0200);
    chk_irq("R4 disabled source no irq", 1'b1);
    irq_en = 16'h0200;
    @(negedge clk);
    chk_irq("R4 enabled bit drives irq", 1'b0);
    tick(5);
    chk("R3 bits held", 16'hFFFF, 16'h0224);

    // read with a repeat and a new event inside
    @(negedge clk) rd_start = 1; @(negedge clk) rd_start = 0;
    @(negedge clk) spi_frame_err = 1; @(negedge clk) spi_frame_err = 0;
    @(negedge clk) cmp_rise[0] = 1; @(negedge clk) cmp_rise[0] = 0;
    @(negedge clk) rd_end = 1; @(negedge clk) rd_end = 0;
    chk("R5 old bits cleared", 16'h0024, 16'h0000);
    chk("R7 repeat of set bit cleared", 16'h0200, 16'h0000);
    chk("R6 new bit survives", 16'h0001, 16'h0001);
    chk_irq("R4 irq released", 1'b1);

    @(negedge clk) rd_end = 1; @(negedge clk) rd_end = 0;
    chk("R12 stray rd_end ignored", 16'h0001, 16'h0001);
    @(negedge clk) rd_start = 1; @(negedge clk) rd_start = 0;
    @(negedge clk) cmp_rise[3] = 1; @(negedge clk) cmp_rise[3] = 0;
    @(negedge clk) rd_start = 1; @(negedge clk) rd_start = 0;
    @(negedge clk) rd_end = 1; @(negedge clk) rd_end = 0;
    chk("R12 second rd_start ignored", 16'h0009, 16'h0008);

    @(negedge clk) adc_fault = 1;
    @(negedge clk);
    chk("R2 converter fault bit11", 16'h0800, 16'h0800);
    do_read();
    chk("R8 persisting fault re-sets", 16'h0800, 16'h0800);
    adc_fault = 0;
    do_read();
    chk("R8 fault gone clears", 16'h0800, 16'h0000);

    irq_en = 16'h1000;
    do_read();
    @(negedge clk) eoc_evt = 1; @(negedge clk) eoc_evt = 0;
    chk_irq("R9 eoc pulse starts", 1'b0);
    chk("R2 eoc bit12", 16'h1000, 16'h1000);
    tick(T_EOC - 1);
    chk_irq("R9 eoc pulse last cycle", 1'b0);
    @(negedge clk);
    chk_irq("R9 eoc pulse ends unread", 1'b1);
    chk("R9 bit12 still set", 16'h1000, 16'h1000);
    irq_en = 16'h0000;

    for (int k = 0; k < CRCL - 1; k++) begin
      @(negedge clk) link_crc_bad = 1; @(negedge clk) link_crc_bad = 0;
    end
    chk("R11 five bad no fault", 16'h0100, 16'h0000);
    @(negedge clk) link_crc_good = 1; @(negedge clk) link_crc_good = 0;
    for (int k = 0; k < CRCL - 1; k++) begin
      @(negedge clk) link_crc_bad = 1; @(negedge clk) link_crc_bad = 0;
    end
    @(negedge clk);
    chk("R11 good restarted the run", 16'h0100, 16'h0000);
    @(negedge clk) link_crc_bad = 1; @(negedge clk) link_crc_bad = 0;
    @(negedge clk);
    chk("R11 sixth bad sets fault", 16'h0100, 16'h0100);
    do_read();
    chk("R8 crc fault re-sets", 16'h0100, 16'h0100);
    @(negedge clk) link_crc_good = 1; @(negedge clk) link_crc_good = 0;
    do_read();
    chk("R11 good ends fault", 16'h0100, 16'h0000);

    while (cyc < T_SU - 100) @(negedge clk);
    chk("R10 loss masked at startup", 16'h0400, 16'h0000);
    while (cyc < T_SU + 10) @(negedge clk);
    chk("R10 loss after startup", 16'h0400, 16'h0400);
    feed_on = 1;
    tick(20);
    do_read();
    tick(100);
    chk("R10 beats keep loss clear", 16'h0400, 16'h0000);
    feed_on = 0;
    tick(30);
    chk("R10 short gap no loss", 16'h0400, 16'h0000);
    tick(40);
    chk("R10 long gap loss", 16'h0400, 16'h0400);

    tick(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule